// File: doc/BRIEF.md
# Receive Frame Buffer with Interrupts

This block sits between a byte-stream radio receiver and a host controller. While the block is in a listening mode, it takes the demodulated octets of one frame and stores them in a local buffer. The first octet stored is the frame length. The host drains the buffer through a small register read port. A data read returns the oldest unread octet. A status read returns the latched event flags and clears them. The interrupt mask register can be read and written.

The block raises three events: start of frame, end of frame, and read underrun. Each event latches into a status bit. The single interrupt line is asserted while any latched bit is also enabled in the mask. The host may wait for the end event before draining, or it may start draining as soon as the first octet has landed, pacing itself with the empty indicator. A read that runs ahead of the incoming stream while the frame is still arriving is an underrun. An underrun raises its own event and marks the frame as suspect.

Top module: `rx_frame_buf`

## Requirements
- R1: The mode input accepts frames only in mode code 1 (listen) or mode code 2 (listen with auto-acknowledge). In codes 0 and 3, the start, octet and end inputs have no effect on stored data, pointers, flags or status.
- R2: A start pulse in a listening mode sets status bit 2 and begins a new frame. It rewinds the write and read positions to zero, clears the frame-bad flag, and makes the buffer report empty. Any octet presented in the same cycle is dropped.
- R3: An end pulse in a listening mode while a frame is in progress sets status bit 3 and ends the frame. An end pulse with no frame in progress has no effect.
- R4: Octets are stored in arrival order. A host read at address 0 returns the oldest unread octet and consumes it. If that read coincides with the write of the very octet it targets, it returns the incoming octet and consumes it, with no underrun.
- R5: A read at address 0 with no unread octet returns 8'h00 and consumes nothing. If a frame is in progress, it also sets status bit 6, and frame_bad_o stays high until the next accepted start. After the frame has ended, such a read raises no event.
- R6: empty_o is high exactly when no written octet remains unread. The first octet therefore becomes readable one octet period after the start event, when it is written.
- R7: A read at address 1 returns the latched status byte and clears it in the same cycle. An event that occurs in that same cycle stays latched.
- R8: The mask register is written and read at address 2 and resets to zero. Status bits latch whatever the mask holds. irq_o is high while any status bit is set together with its mask bit. A read at address 3 returns zero.
- R9: The buffer holds 128 octets. Further octets of the same frame are dropped, and the first 128 remain readable.
- R10: After reset, empty_o is high, irq_o and frame_bad_o are low, and the status and mask registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Receiver mode: 0 idle, 1 listen, 2 listen with auto-acknowledge, 3 off |
| sof_i | input | 1 | Start-of-frame detected pulse |
| oct_valid_i | input | 1 | Octet strobe from the demodulator |
| oct_data_i | input | 8 | Received octet |
| eof_i | input | 1 | Frame complete pulse |
| host_rd_i | input | 1 | Host register read strobe |
| host_wr_i | input | 1 | Host register write strobe |
| host_addr_i | input | 2 | Register address: 0 data, 1 status, 2 mask |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, valid in the strobe cycle |
| empty_o | output | 1 | No unread octet present |
| irq_o | output | 1 | Interrupt request |
| frame_bad_o | output | 1 | Current frame suffered an underrun |

## Verification
Frames are streamed at a fixed octet period against four readers. A reader that waits for the end event checks plain storage order. A reader that trails each write by one cycle proves that early draining matches. A reader that fires every cycle must produce an underrun and the bad-frame flag. A reader that strikes in the same cycle as each write separates write-through from a false underrun. Further frames in the two non-listening modes, with a zero mask, and with more than 128 octets isolate mode gating, mask gating and capacity clipping.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE       = 2'd0,
    MODE_LISTEN     = 2'd1,
    MODE_LISTEN_ACK = 2'd2,
    MODE_OFF        = 2'd3
  } rx_mode_e;

  typedef enum logic [1:0] {
    REG_DATA   = 2'd0,
    REG_STATUS = 2'd1,
    REG_MASK   = 2'd2,
    REG_NONE   = 2'd3
  } host_reg_e;

  localparam int unsigned EVT_START_BIT = 2;
  localparam int unsigned EVT_END_BIT   = 3;
  localparam int unsigned EVT_UNDER_BIT = 6;
endpackage

// File: rtl/rxfb_rst_sync.sv
module rxfb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rxfb_wr_ctrl.sv
module rxfb_wr_ctrl #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          listen,
  input  logic          sof_i,
  input  logic          oct_valid_i,
  input  logic          eof_i,
  output logic          sof_acc,
  output logic          eof_acc,
  output logic          wr_en,
  output logic [PW-1:0] wr_cnt,
  output logic          receiving
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          recv_q, recv_d;
  logic          recv_en;
  logic          room;

  assign room    = (cnt_q < PW'(DEPTH));
  assign sof_acc = sof_i & listen;
  assign eof_acc = eof_i & listen & recv_q & ~sof_acc;
  assign wr_en   = oct_valid_i & listen & recv_q & ~sof_acc & room;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (sof_acc) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (wr_en) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_comb begin
    recv_d  = recv_q;
    recv_en = sof_acc | eof_acc;
    if (sof_acc)      recv_d = 1'b1;
    else if (eof_acc) recv_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      recv_q <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (recv_en) recv_q <= recv_d;
    end
  end

  assign wr_cnt    = cnt_q;
  assign receiving = recv_q;
endmodule

// File: rtl/rxfb_mem.sv
module rxfb_mem #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
  end

  assign rdata = store_q[raddr];
endmodule

// File: rtl/rxfb_rd_ctrl.sv
module rxfb_rd_ctrl #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof_acc,
  input  logic          receiving,
  input  logic          data_rd,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_cnt,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] mem_q,
  output logic [PW-1:0] rd_ptr,
  output logic          empty,
  output logic          thru,
  output logic          underrun,
  output logic [DW-1:0] rd_data,
  output logic          frame_bad
);
  logic [PW-1:0] ptr_q, ptr_d;
  logic          ptr_en;
  logic          bad_q, bad_d;
  logic          bad_en;
  logic          stored, avail, pop;

  assign stored   = (ptr_q < wr_cnt);
  assign thru     = wr_en & (wr_cnt == ptr_q);
  assign avail    = stored | thru;
  assign pop      = data_rd & avail;
  assign underrun = data_rd & ~avail & receiving;

  always_comb begin
    if (!avail)    rd_data = '0;
    else if (thru) rd_data = wdata;
    else           rd_data = mem_q;
  end

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = sof_acc | pop;
    if (sof_acc)  ptr_d = '0;
    else if (pop) ptr_d = ptr_q + 1'b1;
  end

  always_comb begin
    bad_d  = bad_q;
    bad_en = sof_acc | underrun;
    if (sof_acc)       bad_d = 1'b0;
    else if (underrun) bad_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      bad_q <= 1'b0;
    end else begin
      if (ptr_en) ptr_q <= ptr_d;
      if (bad_en) bad_q <= bad_d;
    end
  end

  assign rd_ptr    = ptr_q;
  assign empty     = ~stored;
  assign frame_bad = bad_q;
endmodule

// File: rtl/rxfb_irq_regs.sv
module rxfb_irq_regs #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] evt,
  input  logic          stat_rd,
  input  logic          mask_wr,
  input  logic [DW-1:0] mask_wdata,
  output logic [DW-1:0] status,
  output logic [DW-1:0] mask,
  output logic          irq
);
  logic [DW-1:0] status_q;
  logic [DW-1:0] mask_q;

  for (genvar i = 0; i < DW; i++) begin : g_stat
    logic bit_d;
    logic bit_en;
    always_comb begin
      bit_en = stat_rd | evt[i];
      bit_d  = evt[i] | (status_q[i] & ~stat_rd);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      status_q[i] <= 1'b0;
      else if (bit_en) status_q[i] <= bit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  assign status = status_q;
  assign mask   = mask_q;
  assign irq    = |(status_q & mask_q);
endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          sof_i,
  input  logic          oct_valid_i,
  input  logic [DW-1:0] oct_data_i,
  input  logic          eof_i,
  input  logic          host_rd_i,
  input  logic          host_wr_i,
  input  logic [1:0]    host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  output logic          empty_o,
  output logic          irq_o,
  output logic          frame_bad_o
);
  import rxfb_pkg::*;

  localparam int unsigned PW = $clog2(DEPTH + 1);
  localparam int unsigned AW = $clog2(DEPTH);

  logic          rst_sync_n;
  rx_mode_e      mode;
  host_reg_e     reg_sel;
  logic          listen;
  logic          sof_acc, eof_acc, wr_en, receiving;
  logic [PW-1:0] wr_cnt, rd_ptr;
  logic [DW-1:0] mem_q, rd_data;
  logic          thru, underrun;
  logic          data_rd, stat_rd, mask_wr;
  logic [DW-1:0] evt, status, mask;

  assign mode    = rx_mode_e'(mode_i);
  assign reg_sel = host_reg_e'(host_addr_i);
  assign listen  = (mode == MODE_LISTEN) || (mode == MODE_LISTEN_ACK);
  assign data_rd = host_rd_i && (reg_sel == REG_DATA);
  assign stat_rd = host_rd_i && (reg_sel == REG_STATUS);
  assign mask_wr = host_wr_i && (reg_sel == REG_MASK);

  always_comb begin
    evt                = '0;
    evt[EVT_START_BIT] = sof_acc;
    evt[EVT_END_BIT]   = eof_acc;
    evt[EVT_UNDER_BIT] = underrun;
  end

  rxfb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rxfb_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .listen      (listen),
    .sof_i       (sof_i),
    .oct_valid_i (oct_valid_i),
    .eof_i       (eof_i),
    .sof_acc     (sof_acc),
    .eof_acc     (eof_acc),
    .wr_en       (wr_en),
    .wr_cnt      (wr_cnt),
    .receiving   (receiving)
  );

  rxfb_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_cnt[AW-1:0]),
    .wdata (oct_data_i),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (mem_q)
  );

  rxfb_rd_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sof_acc   (sof_acc),
    .receiving (receiving),
    .data_rd   (data_rd),
    .wr_en     (wr_en),
    .wr_cnt    (wr_cnt),
    .wdata     (oct_data_i),
    .mem_q     (mem_q),
    .rd_ptr    (rd_ptr),
    .empty     (empty_o),
    .thru      (thru),
    .underrun  (underrun),
    .rd_data   (rd_data),
    .frame_bad (frame_bad_o)
  );

  rxfb_irq_regs #(.DW(DW)) u_irq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .evt        (evt),
    .stat_rd    (stat_rd),
    .mask_wr    (mask_wr),
    .mask_wdata (host_wdata_i),
    .status     (status),
    .mask       (mask),
    .irq        (irq_o)
  );

  always_comb begin
    unique case (reg_sel)
      REG_DATA:   host_rdata_o = rd_data;
      REG_STATUS: host_rdata_o = status;
      REG_MASK:   host_rdata_o = mask;
      default:    host_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rxfb_checker.sv
module rxfb_checker #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8,
  parameter int unsigned PW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          listen,
  input logic          sof_acc,
  input logic          eof_acc,
  input logic          underrun,
  input logic          stat_rd,
  input logic [DW-1:0] evt,
  input logic [DW-1:0] status,
  input logic [PW-1:0] wr_cnt,
  input logic [PW-1:0] rd_ptr,
  input logic          empty_o,
  input logic          irq_o,
  input logic          frame_bad_o
);
  // R1: outside the listening modes the write position never moves
  assert_idle_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !listen |=> $stable(wr_cnt));

  // R2: an accepted start leaves an empty, clean, rewound buffer
  assert_start_rewinds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sof_acc |=> (empty_o && !frame_bad_o && wr_cnt == '0 && rd_ptr == '0));

  // R3: an accepted end latches its status bit
  assert_end_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eof_acc |=> status[3]);

  // R5: an underrun marks the frame and latches its status bit
  assert_underrun_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !sof_acc) |=> (frame_bad_o && status[6]));

  // R6: the read position never passes the write position
  assert_rd_behind_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= wr_cnt);

  // R7: a status read with no fresh event leaves nothing pending
  assert_status_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && evt == '0) |=> (status == '0 && !irq_o));

  // R9: the write position stays within capacity
  assert_capacity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt <= PW'(DEPTH));
endmodule

bind rx_frame_buf rxfb_checker #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .listen      (listen),
  .sof_acc     (sof_acc),
  .eof_acc     (eof_acc),
  .underrun    (underrun),
  .stat_rd     (stat_rd),
  .evt         (evt),
  .status      (status),
  .wr_cnt      (wr_cnt),
  .rd_ptr      (rd_ptr),
  .empty_o     (empty_o),
  .irq_o       (irq_o),
  .frame_bad_o (frame_bad_o)
);

// File: tb/rx_frame_buf_tb.sv
`timescale 1ns/1ps
module rx_frame_buf_tb;
  localparam int DEPTH = 128;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_i;
  logic       sof_i, oct_valid_i, eof_i;
  logic [7:0] oct_data_i;
  logic       host_rd_i, host_wr_i;
  logic [1:0] host_addr_i;
  logic [7:0] host_wdata_i;
  logic [7:0] host_rdata_o;
  logic       empty_o, irq_o, frame_bad_o;

  always #2 clk = ~clk;

  rx_frame_buf u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sof_i(sof_i),
    .oct_valid_i(oct_valid_i), .oct_data_i(oct_data_i), .eof_i(eof_i),
    .host_rd_i(host_rd_i), .host_wr_i(host_wr_i), .host_addr_i(host_addr_i),
    .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
    .empty_o(empty_o), .irq_o(irq_o), .frame_bad_o(frame_bad_o)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference model state
  int m_buf [DEPTH];
  int m_wr, m_rd, m_stat, m_mask;
  bit m_recv, m_bad;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // one clock: drive at negedge, compare, model the edge
  task automatic cyc(input int md, input bit sof, input bit ov, input int od,
                     input bit eof, input bit rd, input bit wr, input int addr,
                     input int wd);
    bit listen, sof_a, oct_a, eof_a, rd_d, thru, avail, under;
    int exp_rd;
    mode_i = md[1:0]; sof_i = sof; oct_valid_i = ov; oct_data_i = od[7:0];
    eof_i = eof; host_rd_i = rd; host_wr_i = wr; host_addr_i = addr[1:0];
    host_wdata_i = wd[7:0];
    #1;
    listen = (md == 1) || (md == 2);
    sof_a  = sof && listen;
    oct_a  = ov && listen && m_recv && !sof_a && (m_wr < DEPTH);
    eof_a  = eof && listen && m_recv && !sof_a;
    rd_d   = rd && addr == 0;
    thru   = oct_a && (m_wr == m_rd);
    avail  = (m_rd < m_wr) || thru;
    under  = rd_d && !avail && m_recv;
    case (addr)
      0: exp_rd = avail ? (thru ? (od & 255) : m_buf[m_rd]) : 0;
      1: exp_rd = m_stat;
      2: exp_rd = m_mask;
      default: exp_rd = 0;
    endcase
    chk("R6 empty_o", {31'd0, empty_o}, {31'd0, !(m_rd < m_wr)});
    chk("R8 irq_o", {31'd0, irq_o}, {31'd0, (m_stat & m_mask) != 0});
    chk("R5 frame_bad_o", {31'd0, frame_bad_o}, {31'd0, m_bad});
    if (rd) begin
      if (addr == 0)      chk(thru ? "R4 write-through data" : (avail ? "R4 data read" : "R5 empty read"), {24'd0, host_rdata_o}, exp_rd);
      else if (addr == 1) chk("R7 status read", {24'd0, host_rdata_o}, exp_rd);
      else                chk("R8 mask/none read", {24'd0, host_rdata_o}, exp_rd);
    end
    @(posedge clk);
    if (oct_a) begin m_buf[m_wr] = od & 255; m_wr++; end
    if (rd_d && avail) m_rd++;
    if (under) m_bad = 1;
    if (eof_a) m_recv = 0;
    if (sof_a) begin m_wr = 0; m_rd = 0; m_recv = 1; m_bad = 0; end
    if (rd && addr == 1) m_stat = 0;
    if (sof_a) m_stat |= 32'h04;
    if (eof_a) m_stat |= 32'h08;
    if (under) m_stat |= 32'h40;
    if (wr && addr == 2) m_mask = wd & 255;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic host_read(input int addr);
    cyc(1, 0, 0, 0, 0, 1, 0, addr, 0);
  endtask

  task automatic host_write_mask(input int v);
    cyc(1, 0, 0, 0, 0, 0, 1, 2, v);
  endtask

  // rmode 0: no reads; 1: trail each write by one cycle; 2: read every cycle;
  // 3: read in the same cycle as each write
  task automatic run_frame(input int len, input int per, input int rmode,
                           input int md, input int seed);
    int total = per * len + 3;
    for (int c = 0; c < total; c++) begin
      bit sof = (c == 0);
      bit ov  = (c > 0) && (c % per == 0) && (c / per <= len);
      int k   = c / per - 1;
      int od  = ov ? ((k == 0) ? (len & 255) : ((k * 37 + len * 11 + seed) & 255)) : 0;
      bit eof = (c == per * len + 1);
      bit rd  = 0;
      case (rmode)
        1: rd = (c > per) && (c % per == 1 % per);
        2: rd = (c >= 1);
        3: rd = ov;
        default: rd = 0;
      endcase
      cyc(md, sof, ov, od, eof, rd, 0, 0, 0);
    end
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) host_read(0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles == 150000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    m_wr = 0; m_rd = 0; m_stat = 0; m_mask = 0; m_recv = 0; m_bad = 0;
    rst_n = 1'b0;
    mode_i = 0; sof_i = 0; oct_valid_i = 0; oct_data_i = 0; eof_i = 0;
    host_rd_i = 0; host_wr_i = 0; host_addr_i = 0; host_wdata_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk("R10 empty_o after reset", {31'd0, empty_o}, 32'd1);
    chk("R10 irq_o after reset", {31'd0, irq_o}, 32'd0);
    chk("R10 frame_bad_o after reset", {31'd0, frame_bad_o}, 32'd0);
    host_read(1);
    host_read(2);
    host_read(3);

    host_write_mask(32'h4C);
    host_read(2);

    // R4 drain after end event, mode 1
    run_frame(10, 4, 0, 1, 3);
    host_read(1);
    drain(11);

    // R4/R6 low-latency draining in mode 2
    run_frame(20, 4, 1, 2, 5);
    host_read(1);
    drain(2);

    // R5 fast reader underruns
    run_frame(8, 3, 2, 1, 7);
    host_read(1);
    drain(9);

    // R4 write-through reads, no underrun
    run_frame(6, 3, 3, 1, 9);
    host_read(1);
    drain(2);

    // R1 non-listening modes ignore a frame
    run_frame(5, 2, 0, 0, 11);
    host_read(1);
    run_frame(5, 2, 0, 3, 13);
    host_read(1);
    drain(2);

    // R8 status latches with zero mask, irq follows when enabled
    host_write_mask(0);
    run_frame(3, 2, 0, 1, 15);
    idle(2);
    host_write_mask(32'h08);
    idle(1);
    host_read(1);
    drain(4);

    // R3 end with no frame in progress is ignored
    cyc(1, 0, 0, 0, 1, 0, 0, 0, 0);
    host_read(1);

    // R9 capacity clipping
    host_write_mask(32'hFF);
    run_frame(130, 1, 0, 1, 17);
    host_read(1);
    drain(DEPTH + 2);

    // R2 new start mid-drain rewinds
    run_frame(4, 2, 0, 1, 19);
    drain(2);
    run_frame(5, 2, 0, 2, 21);
    host_read(1);
    drain(6);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule